// File: doc/BRIEF.md
# Serial Handshake Flow Control

This block sits between the transmitter and receiver of one serial channel and a single shared handshake pin. Two mode inputs give the pin one of three roles. It can be a plain general-purpose pin. It can be a clear-to-send input that gates when a new transmit frame may begin. It can be a request-to-send output that tells the far end the receiver can take data.

In clear-to-send mode the pin level is synchronised, and the block drives a transmit-permit signal from it. If the far end raises the pin while a frame is in flight, that frame still completes. Only after it ends is the permit withdrawn.

In request-to-send mode the block drives the pin low once the receiver reports that it is ready. It releases the pin at the first falling edge of the serial clock that follows. It does not assert the pin again until the receiver's ready status drops and rises again. The serial clock is sampled on the system clock, and edges are found by comparing the new sample with the previous one.

Top module: `hs_flow_ctl`

## Requirements
- R1: While reset is applied and on the first sample after it, tx_permit_o is 0, pin_oe_o is 0 and pin_o is 1.
- R2: General-purpose mode (hs_off_i=1): one cycle after a change, pin_o equals gpio_out_i and pin_oe_o equals gpio_dir_i (1 = output). tx_permit_o is 1 and pin_i has no effect on it.
- R3: Clear-to-send mode (hs_off_i=0, hs_sel_i=0): pin_oe_o is 0 and pin_o is 1. A change on pin_i reaches tx_permit_o exactly SYNC_STAGES+1 cycles later. tx_permit_o is 1 when pin_i is low.
- R4: In clear-to-send mode, tx_permit_o stays 1 while tx_busy_i=1 and tx_done_i=0, even when pin_i is high. It falls one cycle after tx_done_i pulses with pin_i high.
- R5: In clear-to-send mode with pin_i high and no frame in flight (tx_busy_i=0), tx_permit_o is 0.
- R6: Request-to-send mode (hs_off_i=0, hs_sel_i=1): pin_oe_o is 1. pin_o goes low one cycle after rx_ready_i rises.
- R7: In request-to-send mode, pin_o returns high exactly SYNC_STAGES+1 cycles after the first falling edge of sclk_i. It stays high through later sclk_i edges while rx_ready_i stays 1.
- R8: In request-to-send mode, pin_o is high one cycle after rx_ready_i goes to 0. A fresh rise of rx_ready_i drives it low again.
- R9: A rising edge of sclk_i does not release a low request-to-send output.
- R10: In request-to-send mode, tx_permit_o is 1 and pin_i has no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hs_off_i | input | 1 | 1 = handshake off, pin is general-purpose |
| hs_sel_i | input | 1 | With hs_off_i=0: 0 = clear-to-send, 1 = request-to-send |
| gpio_dir_i | input | 1 | General-purpose direction, 1 = output |
| gpio_out_i | input | 1 | General-purpose output level |
| tx_busy_i | input | 1 | Transmitter has a frame in flight |
| tx_done_i | input | 1 | Transmitter frame-complete pulse |
| rx_ready_i | input | 1 | Receiver can accept data |
| sclk_i | input | 1 | Serial clock pin level |
| pin_i | input | 1 | Handshake pin input level |
| tx_permit_o | output | 1 | Transmitter may start or continue a frame |
| pin_o | output | 1 | Handshake pin output level |
| pin_oe_o | output | 1 | Handshake pin output enable |

## Verification
The bench builds the block with SYNC_STAGES=3, one stage deeper than the default. It derives every latency it checks from that value. The pin-to-permit delay and the sclk-fall-to-release delay are each sampled in the last cycle before they may change and again in the cycle where they must change. With the deeper chain, a synchroniser that drops or adds a stage shows up as a timing error, not as a level that is only a little late.

// File: rtl/hs_flow_pkg.sv
package hs_flow_pkg;
  typedef enum logic [1:0] {
    HS_GPIO = 2'd0,
    HS_CTS  = 2'd1,
    HS_RTS  = 2'd2
  } hs_mode_e;

  function automatic hs_mode_e hs_decode(input logic off, input logic sel);
    if (off)      return HS_GPIO;
    else if (sel) return HS_RTS;
    else          return HS_CTS;
  endfunction
endpackage

// File: rtl/hs_sync.sv
module hs_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] stg_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stg
      if (i == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni)
          if (!rst_ni) stg_q[i] <= RST_VAL;
          else         stg_q[i] <= d_i;
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni)
          if (!rst_ni) stg_q[i] <= RST_VAL;
          else         stg_q[i] <= stg_q[i-1];
      end
    end
  endgenerate

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/hs_fall_det.sv
module hs_fall_det #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sig_i,
  output logic fall_o
);
  logic sig_s, prev_q;

  hs_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (sig_i),
    .q_o   (sig_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) prev_q <= 1'b1;
    else         prev_q <= sig_s;

  assign fall_o = prev_q & ~sig_s;
endmodule

// File: rtl/hs_rts_ctl.sv
module hs_rts_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic rx_ready_i,
  input  logic sclk_fall_i,
  output logic rts_low_o
);
  logic low_q, used_q, low_d, used_d;

  // used: request already released by an sclk fall; rearm needs ready to drop
  always_comb begin
    used_d = en_i & rx_ready_i & (used_q | (sclk_fall_i & low_q));
    low_d  = en_i & rx_ready_i & ~used_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      low_q  <= 1'b0;
      used_q <= 1'b0;
    end else begin
      low_q  <= low_d;
      used_q <= used_d;
    end

  assign rts_low_o = low_q;
endmodule

// File: rtl/hs_flow_ctl.sv
module hs_flow_ctl
  import hs_flow_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hs_off_i,
  input  logic hs_sel_i,
  input  logic gpio_dir_i,
  input  logic gpio_out_i,
  input  logic tx_busy_i,
  input  logic tx_done_i,
  input  logic rx_ready_i,
  input  logic sclk_i,
  input  logic pin_i,
  output logic tx_permit_o,
  output logic pin_o,
  output logic pin_oe_o
);
  hs_mode_e mode_d, mode_q;
  logic     cts_s, sclk_fall, rts_low;
  logic     permit_q, permit_d, oe_q, gpio_q;

  assign mode_d = hs_decode(hs_off_i, hs_sel_i);

  hs_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_cts_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (cts_s)
  );

  hs_fall_det #(.SYNC_STAGES(SYNC_STAGES)) u_sclk_fall (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .sig_i (sclk_i),
    .fall_o(sclk_fall)
  );

  hs_rts_ctl u_rts (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (mode_d == HS_RTS),
    .rx_ready_i (rx_ready_i),
    .sclk_fall_i(sclk_fall),
    .rts_low_o  (rts_low)
  );

  // frame in flight keeps permission until it completes
  always_comb begin
    if (mode_d == HS_CTS) permit_d = ~cts_s | (tx_busy_i & ~tx_done_i);
    else                  permit_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      mode_q   <= HS_GPIO;
      permit_q <= 1'b0;
      oe_q     <= 1'b0;
      gpio_q   <= 1'b1;
    end else begin
      mode_q   <= mode_d;
      permit_q <= permit_d;
      oe_q     <= (mode_d == HS_RTS) | ((mode_d == HS_GPIO) & gpio_dir_i);
      gpio_q   <= gpio_out_i;
    end

  always_comb begin
    unique case (mode_q)
      HS_GPIO: pin_o = gpio_q;
      HS_RTS:  pin_o = ~rts_low;
      default: pin_o = 1'b1;
    endcase
  end

  assign tx_permit_o = permit_q;
  assign pin_oe_o    = oe_q;
endmodule

// File: rtl/hs_flow_chk.sv
module hs_flow_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic hs_off_i,
  input logic hs_sel_i,
  input logic gpio_dir_i,
  input logic gpio_out_i,
  input logic tx_busy_i,
  input logic tx_done_i,
  input logic rx_ready_i,
  input logic tx_permit_o,
  input logic pin_o,
  input logic pin_oe_o
);
  logic live_q;
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) live_q <= 1'b0;
    else         live_q <= 1'b1;

  a_r1_reset_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !live_q |-> (!tx_permit_o && !pin_oe_o && pin_o));

  a_r2_gpio_follow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live_q && $past(hs_off_i)) |->
      (pin_oe_o == $past(gpio_dir_i) && pin_o == $past(gpio_out_i)));

  a_r3_cts_no_drive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live_q && $past(!hs_off_i && !hs_sel_i)) |-> (!pin_oe_o && pin_o));

  a_r4_frame_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live_q && $past(!hs_off_i && !hs_sel_i && tx_busy_i && !tx_done_i)) |-> tx_permit_o);

  a_r6_rts_drive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live_q && $past(!hs_off_i && hs_sel_i)) |-> pin_oe_o);

  a_r8_unready_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live_q && $past(!hs_off_i && hs_sel_i && !rx_ready_i)) |-> pin_o);

  a_r10_permit_free: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live_q && $past(hs_off_i || hs_sel_i)) |-> tx_permit_o);
endmodule

bind hs_flow_ctl hs_flow_chk u_chk (.*);

// File: tb/tb_hs_flow_ctl.sv
module tb_hs_flow_ctl;
  localparam int SYNC = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic off = 1'b1, sel = 1'b0, dir = 1'b0, gout = 1'b0;
  logic busy = 1'b0, done = 1'b0, rdy = 1'b0, sclk = 1'b1, pin = 1'b1;
  logic permit, pout, poe;
  int   n_chk = 0, n_fail = 0;
  bit   finished = 1'b0;

  always #4 clk = ~clk;

  hs_flow_ctl #(.SYNC_STAGES(SYNC)) dut (
    .clk_i(clk), .rst_ni(rst_n), .hs_off_i(off), .hs_sel_i(sel),
    .gpio_dir_i(dir), .gpio_out_i(gout), .tx_busy_i(busy), .tx_done_i(done),
    .rx_ready_i(rdy), .sclk_i(sclk), .pin_i(pin),
    .tx_permit_o(permit), .pin_o(pout), .pin_oe_o(poe)
  );

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    wait_cyc(2);
    check("R1 permit in reset", permit, 1'b0);
    check("R1 oe in reset", poe, 1'b0);
    check("R1 pin in reset", pout, 1'b1);
    rst_n = 1'b1;
    #1;
    check("R1 permit after release", permit, 1'b0);
    check("R1 oe after release", poe, 1'b0);
  endtask

  task automatic t_gpio();
    off = 1'b1; dir = 1'b1; gout = 1'b0; pin = 1'b1;
    wait_cyc(1);
    check("R2 oe follows dir", poe, 1'b1);
    check("R2 pin follows out", pout, 1'b0);
    gout = 1'b1;
    wait_cyc(1);
    check("R2 pin follows out high", pout, 1'b1);
    dir = 1'b0;
    wait_cyc(1);
    check("R2 oe off", poe, 1'b0);
    pin = 1'b1;
    wait_cyc(SYNC + 3);
    check("R2 permit ignores pin", permit, 1'b1);
  endtask

  task automatic t_cts_basic();
    off = 1'b0; sel = 1'b0; pin = 1'b1; busy = 1'b0;
    wait_cyc(SYNC + 3);
    check("R3 oe off in cts", poe, 1'b0);
    check("R3 pin high in cts", pout, 1'b1);
    check("R5 no permit when high", permit, 1'b0);
    pin = 1'b0;
    wait_cyc(SYNC);
    check("R3 permit not yet", permit, 1'b0);
    wait_cyc(1);
    check("R3 permit at latency", permit, 1'b1);
    pin = 1'b1;
    wait_cyc(SYNC);
    check("R3 permit holds before latency", permit, 1'b1);
    wait_cyc(1);
    check("R5 permit drops at latency", permit, 1'b0);
  endtask

  task automatic t_cts_midframe();
    pin = 1'b0;
    wait_cyc(SYNC + 2);
    busy = 1'b1;
    wait_cyc(2);
    pin = 1'b1;
    wait_cyc(SYNC + 4);
    check("R4 permit held mid frame", permit, 1'b1);
    done = 1'b1;
    wait_cyc(1);
    done = 1'b0; busy = 1'b0;
    check("R4 permit drops after done", permit, 1'b0);
    wait_cyc(2);
    check("R5 permit stays low", permit, 1'b0);
  endtask

  task automatic t_rts();
    off = 1'b0; sel = 1'b1; rdy = 1'b0; sclk = 1'b1;
    wait_cyc(SYNC + 3);
    check("R6 oe on in rts", poe, 1'b1);
    check("R8 pin high when not ready", pout, 1'b1);
    rdy = 1'b1;
    wait_cyc(1);
    check("R6 pin low after ready", pout, 1'b0);
    sclk = 1'b0;
    wait_cyc(SYNC);
    check("R7 still low before latency", pout, 1'b0);
    wait_cyc(1);
    check("R7 high after sclk fall", pout, 1'b1);
    sclk = 1'b1;
    wait_cyc(SYNC + 2);
    sclk = 1'b0;
    wait_cyc(SYNC + 2);
    check("R7 stays high on later edges", pout, 1'b1);
    rdy = 1'b0;
    wait_cyc(1);
    check("R8 high when not ready", pout, 1'b1);
    rdy = 1'b1;
    wait_cyc(1);
    check("R8 rearmed low", pout, 1'b0);
  endtask

  task automatic t_rts_rise_and_pin();
    sclk = 1'b1;
    wait_cyc(SYNC + 4);
    check("R9 sclk rise keeps low", pout, 1'b0);
    rdy = 1'b0;
    wait_cyc(1);
    check("R8 drop releases", pout, 1'b1);
    pin = 1'b1;
    wait_cyc(SYNC + 3);
    check("R10 permit ignores pin high", permit, 1'b1);
    pin = 1'b0;
    wait_cyc(SYNC + 3);
    check("R10 permit with pin low", permit, 1'b1);
  endtask

  initial begin
    t_reset();
    t_gpio();
    t_cts_basic();
    t_cts_midframe();
    t_rts();
    t_rts_rise_and_pin();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule